// File: doc/BRIEF.md
# NAND address cycle sequencer

This block turns one NAND address request into the string of address bytes a flash device expects, handing them out one at a time to a downstream address-latch engine. A request carries a column address and a row (page) address, a presence flag for each, a page-size code and a row byte mask. Column bytes go out first: one byte for small pages, two for the larger page sizes, where the upper byte holds only the column bits that page size needs. Row bytes follow, least significant byte first. Their number is not fixed: it comes from shifting the row mask right by a byte after each row byte until nothing is left.

Each byte is offered with a valid/ready handshake and held until the engine accepts it. A one-cycle completion pulse marks the end of the sequence. A request with neither part present completes at once without offering any byte. Command bytes and data transfer belong to other blocks.

Top module: `nand_addr_seq`

## Requirements
- R1: While reset is low and in the first cycle after it, `addr_valid` and `done` are 0.
- R2: `start` is taken only when `addr_valid` is 0. A `start` pulse, or any change of the request inputs, while a sequence is in flight changes neither the bytes offered nor their order.
- R3: When `col_present` is 1, the first byte offered is `col_addr[7:0]`.
- R4: The `page_size` code sets the number of column bytes. Code 0 (512-byte page) and code 3 (reserved) give one byte. Code 1 (2048-byte page) gives a second byte `{4'b0, col_addr[11:8]}`. Code 2 (4096-byte page) gives a second byte `{3'b0, col_addr[12:8]}`.
- R5: When `row_present` is 1, row bytes follow all column bytes, least significant byte first, with byte i equal to `row_addr[8i+7:8i]`. The count is the smallest k of at least 1 for which `row_mask >> (8k)` is zero, so a row always emits at least one byte.
- R6: A part whose presence flag is 0 emits no bytes. With both flags at 0, `done` rises the cycle after `start` is taken and no byte is offered.
- R7: While `addr_valid` is 1 and `addr_ready` is 0, `addr_valid` and `addr_byte` hold their values. The next byte is offered only after an accept (`addr_valid` and `addr_ready` both 1 at a clock edge). The first byte is offered the cycle after `start` is taken.
- R8: `done` is high for exactly one cycle, the cycle after the final byte is accepted, and is never high while `addr_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a new address sequence |
| col_present | input | 1 | Column part is present |
| col_addr | input | COL_W | Column address |
| page_size | input | 2 | Page size code: 0 = 512, 1 = 2048, 2 = 4096, 3 = reserved (treated as 512) |
| row_present | input | 1 | Row part is present |
| row_addr | input | ROW_W | Row (page) address |
| row_mask | input | ROW_W | Row mask that sets the row byte count |
| addr_valid | output | 1 | An address byte is offered |
| addr_byte | output | 8 | Offered address byte |
| addr_ready | input | 1 | Downstream engine accepts the offered byte |
| done | output | 1 | One-cycle pulse after the final byte is accepted |

## Verification
Two events can share a clock edge: acceptance of the last byte of one sequence and a new `start` request. The last accept ends the sequence, while a `start` seen at that same edge must be ignored because `addr_valid` is still high. The bench drives `start` high at random while bytes are in flight, including the edge of the final accept, and also scrambles the request inputs. It then checks that every offered byte matches the first request and that `done` appears exactly once, one cycle after the final accept. Back-to-back runs with `addr_ready` held high and runs with sparse random ready cover both the no-stall and the held-byte paths.

// File: rtl/nand_addr_pkg.sv
// Package: shared encodings for the NAND address cycle sequencer.
// Assumes: address bytes are 8 bits wide, as on every NAND bus.
package nand_addr_pkg;

    localparam int ADDR_BYTE_W = 8;

    // Page size selector; the reserved code behaves like the small page.
    typedef enum logic [1:0] {
        PG_512 = 2'd0,
        PG_2K  = 2'd1,
        PG_4K  = 2'd2,
        PG_RSV = 2'd3
    } page_size_e;

    // Number of column bytes for a request.
    function automatic logic [1:0] col_byte_count(input logic present, input page_size_e pg);
        if (!present)
            return 2'd0;
        else if (pg == PG_2K || pg == PG_4K)
            return 2'd2;
        else
            return 2'd1;
    endfunction

endpackage

// File: rtl/nand_col_stage.sv
// Module: nand_col_stage
// Holds the column bytes of one request and steps through them.
// Assumes: COL_W >= 13 so that the widest upper column field exists;
// load and adv are never high together (the controller guarantees it).
module nand_col_stage
    import nand_addr_pkg::*;
#(
    parameter int COL_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic                   adv,
    input  logic                   col_present,
    input  logic [COL_W-1:0]       col_addr,
    input  logic [1:0]             page_size,
    output logic [ADDR_BYTE_W-1:0] col_byte,
    output logic                   col_pend,
    output logic                   col_last
);

    logic [ADDR_BYTE_W-1:0] lo_q;
    logic [ADDR_BYTE_W-1:0] hi_q;
    logic [ADDR_BYTE_W-1:0] hi_n;
    logic [1:0]             cnt_q;
    page_size_e             pg;

    assign pg = page_size_e'(page_size);

    // Upper column byte: width of the field depends on the page size.
    always_comb begin
        case (pg)
            PG_2K:   hi_n = {4'b0, col_addr[11:8]};
            PG_4K:   hi_n = {3'b0, col_addr[12:8]};
            default: hi_n = '0;
        endcase
    end

    // Capture the bytes on load; shift the upper byte down on each accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q  <= '0;
            hi_q  <= '0;
            cnt_q <= 2'd0;
        end else if (load) begin
            lo_q  <= col_addr[ADDR_BYTE_W-1:0];
            hi_q  <= hi_n;
            cnt_q <= col_byte_count(col_present, pg);
        end else if (adv) begin
            lo_q  <= hi_q;
            hi_q  <= '0;
            cnt_q <= cnt_q - 2'd1;
        end
    end

    assign col_byte = lo_q;
    assign col_pend = (cnt_q != 2'd0);
    assign col_last = (cnt_q == 2'd1);

    AST_COL_ADV_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> col_pend) else $error("column advanced with no byte left"); // R7

    AST_COL_FIRST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        load && col_present |=> col_pend && col_byte == $past(col_addr[7:0]))
        else $error("first column byte is not the low column byte"); // R3

endmodule

// File: rtl/nand_row_stage.sv
// Module: nand_row_stage
// Holds the row address and its mask, shifting both by one byte per accept.
// Assumes: ROW_W is a multiple of 8; a present row always emits one byte.
module nand_row_stage
    import nand_addr_pkg::*;
#(
    parameter int ROW_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic                   adv,
    input  logic                   row_present,
    input  logic [ROW_W-1:0]       row_addr,
    input  logic [ROW_W-1:0]       row_mask,
    output logic [ADDR_BYTE_W-1:0] row_byte,
    output logic                   row_pend,
    output logic                   row_last
);

    logic [ROW_W-1:0] row_q;
    logic [ROW_W-1:0] mask_q;
    logic [ROW_W-1:0] mask_shift;
    logic             pend_q;

    assign mask_shift = mask_q >> ADDR_BYTE_W;

    // Load the row; after each accept shift row and mask, stop on empty mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q  <= '0;
            mask_q <= '0;
            pend_q <= 1'b0;
        end else if (load) begin
            row_q  <= row_addr;
            mask_q <= row_mask;
            pend_q <= row_present;
        end else if (adv) begin
            row_q  <= row_q >> ADDR_BYTE_W;
            mask_q <= mask_shift;
            pend_q <= (mask_shift != '0);
        end
    end

    assign row_byte = row_q[ADDR_BYTE_W-1:0];
    assign row_pend = pend_q;
    assign row_last = (mask_shift == '0);

    AST_ROW_ADV_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> row_pend) else $error("row advanced with no byte left"); // R5

    AST_ROW_AT_LEAST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        load && row_present |=> row_pend) else $error("present row emitted nothing"); // R5

endmodule

// File: rtl/nand_addr_ctl.sv
// Module: nand_addr_ctl
// Handshake and completion control: takes a request when idle, routes
// accepts to the column stage first and then the row stage, and raises
// the completion pulse.
// Assumes: the stages report pending and last-byte status combinationally.
module nand_addr_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic col_present,
    input  logic row_present,
    input  logic col_pend,
    input  logic col_last,
    input  logic row_pend,
    input  logic row_last,
    input  logic addr_ready,
    output logic load,
    output logic col_adv,
    output logic row_adv,
    output logic addr_valid,
    output logic done
);

    logic fire;
    logic last_byte;
    logic done_q;

    // Handshake decode and routing of an accept to the active stage.
    always_comb begin
        addr_valid = col_pend || row_pend;
        load       = start && !addr_valid;
        fire       = addr_valid && addr_ready;
        col_adv    = fire && col_pend;
        row_adv    = fire && !col_pend;
        last_byte  = col_pend ? (col_last && !row_pend) : row_last;
    end

    // Completion pulse: after the final accept, or at once for an empty request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_q <= 1'b0;
        else
            done_q <= (fire && last_byte) || (load && !col_present && !row_present);
    end

    assign done = done_q;

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !addr_valid) else $error("done while a byte is offered"); // R8

    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(fire) || $past(load)) else $error("done without accept or request"); // R8

    AST_BUSY_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid && start && !addr_ready |=> addr_valid) else $error("start disturbed a sequence"); // R2

endmodule

// File: rtl/nand_addr_seq.sv
// Module: nand_addr_seq (top)
// NAND address cycle sequencer: emits column bytes then row bytes, one per
// valid/ready handshake, and pulses done after the last one.
// Assumes: COL_W >= 13, ROW_W a multiple of 8.
module nand_addr_seq
    import nand_addr_pkg::*;
#(
    parameter int COL_W = 16,
    parameter int ROW_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             col_present,
    input  logic [COL_W-1:0] col_addr,
    input  logic [1:0]       page_size,
    input  logic             row_present,
    input  logic [ROW_W-1:0] row_addr,
    input  logic [ROW_W-1:0] row_mask,
    output logic             addr_valid,
    output logic [7:0]       addr_byte,
    input  logic             addr_ready,
    output logic             done
);

    logic                   load;
    logic                   col_adv;
    logic                   row_adv;
    logic [ADDR_BYTE_W-1:0] col_byte;
    logic [ADDR_BYTE_W-1:0] row_byte;
    logic                   col_pend;
    logic                   col_last;
    logic                   row_pend;
    logic                   row_last;

    nand_col_stage #(.COL_W(COL_W)) u_col (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .adv        (col_adv),
        .col_present(col_present),
        .col_addr   (col_addr),
        .page_size  (page_size),
        .col_byte   (col_byte),
        .col_pend   (col_pend),
        .col_last   (col_last)
    );

    nand_row_stage #(.ROW_W(ROW_W)) u_row (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .adv        (row_adv),
        .row_present(row_present),
        .row_addr   (row_addr),
        .row_mask   (row_mask),
        .row_byte   (row_byte),
        .row_pend   (row_pend),
        .row_last   (row_last)
    );

    nand_addr_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .col_present(col_present),
        .row_present(row_present),
        .col_pend   (col_pend),
        .col_last   (col_last),
        .row_pend   (row_pend),
        .row_last   (row_last),
        .addr_ready (addr_ready),
        .load       (load),
        .col_adv    (col_adv),
        .row_adv    (row_adv),
        .addr_valid (addr_valid),
        .done       (done)
    );

    // Output byte: column stage has priority over the row stage.
    always_comb begin
        if (col_pend)
            addr_byte = col_byte;
        else if (row_pend)
            addr_byte = row_byte;
        else
            addr_byte = '0;
    end

    AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid && !addr_ready |=> addr_valid && $stable(addr_byte))
        else $error("offered byte changed before accept"); // R7

endmodule

// File: tb/nand_addr_seq_test.sv
module nand_addr_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int COL_W      = 16;
    localparam int ROW_W      = 32;
    localparam int ROW_BYTES  = ROW_W / 8;
    localparam int WATCHDOG   = 150000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             col_present = 1'b0;
    logic [COL_W-1:0] col_addr = '0;
    logic [1:0]       page_size = 2'd0;
    logic             row_present = 1'b0;
    logic [ROW_W-1:0] row_addr = '0;
    logic [ROW_W-1:0] row_mask = '0;
    logic             addr_valid;
    logic [7:0]       addr_byte;
    logic             addr_ready = 1'b0;
    logic             done;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit finished = 0;

    logic [7:0] exp_b [0:7];
    string      exp_t [0:7];
    int         n_exp;

    nand_addr_seq #(.COL_W(COL_W), .ROW_W(ROW_W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .col_present(col_present),
        .col_addr   (col_addr),
        .page_size  (page_size),
        .row_present(row_present),
        .row_addr   (row_addr),
        .row_mask   (row_mask),
        .addr_valid (addr_valid),
        .addr_byte  (addr_byte),
        .addr_ready (addr_ready),
        .done       (done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected byte list from the requirements (R3, R4, R5, R6).
    task automatic build_expect(input logic cv, input logic [COL_W-1:0] col, input logic [1:0] pg,
                                input logic rv, input logic [ROW_W-1:0] row, input logic [ROW_W-1:0] mask);
        n_exp = 0;
        if (cv) begin
            exp_b[n_exp] = col[7:0]; exp_t[n_exp] = "R3 column low byte"; n_exp++;
            if (pg == 2'd1) begin
                exp_b[n_exp] = {4'b0, col[11:8]}; exp_t[n_exp] = "R4 2048 upper column"; n_exp++;
            end else if (pg == 2'd2) begin
                exp_b[n_exp] = {3'b0, col[12:8]}; exp_t[n_exp] = "R4 4096 upper column"; n_exp++;
            end
        end
        if (rv) begin
            logic [ROW_W-1:0] m;
            int k;
            m = mask >> 8;
            k = 1;
            while (m != '0) begin
                k++;
                m = m >> 8;
            end
            for (int i = 0; i < k; i++) begin
                exp_b[n_exp] = 8'((row >> (8*i)) & 32'hFF);
                exp_t[n_exp] = "R5 row byte";
                n_exp++;
            end
        end
    endtask

    // One request, with ready duty and optional disturbance while busy (R2).
    task automatic run_cmd(input logic cv, input logic [COL_W-1:0] col, input logic [1:0] pg,
                           input logic rv, input logic [ROW_W-1:0] row, input logic [ROW_W-1:0] mask,
                           input int ready_pct, input bit poke);
        int idx;
        int guard;
        string dtag;
        build_expect(cv, col, pg, rv, row, mask);
        dtag = (cv && rv) ? "R8 done timing" : "R6 absent part / done timing";
        @(negedge clk);
        col_present = cv; col_addr = col; page_size = pg;
        row_present = rv; row_addr = row; row_mask = mask;
        start = 1'b1; addr_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        idx = 0;
        guard = 0;
        while (1) begin
            if (idx == n_exp) begin
                check(done, 1'b1, dtag);
                check(addr_valid, 1'b0, "R8 valid low with done");
                break;
            end
            check(addr_valid, 1'b1, "R7 byte offered");
            check(addr_byte, exp_b[idx], poke ? {exp_t[idx], " (R2 busy start)"} : exp_t[idx]);
            check(done, 1'b0, "R8 no done mid-sequence");
            addr_ready = (($urandom % 100) < 32'(ready_pct));
            if (poke) begin
                start = $urandom % 2;
                col_present = $urandom % 2; col_addr = COL_W'($urandom);
                page_size = 2'($urandom); row_present = $urandom % 2;
                row_addr = $urandom; row_mask = $urandom;
            end
            @(negedge clk);
            if (addr_ready) idx++;
            guard++;
            if (guard > 400) begin
                check(32'(idx), 32'(n_exp), "R7 sequence stalled");
                break;
            end
        end
        start = 1'b0; addr_ready = 1'b0;
        @(negedge clk);
        check(done, 1'b0, "R8 done single cycle");
        check(addr_valid, 1'b0, "R2 no restart after busy start");
    endtask

    function automatic logic [ROW_W-1:0] rand_mask();
        int n;
        n = $urandom % (ROW_BYTES + 1);
        if (n == 0) return '0;
        return (ROW_W'(1) << (8*(n-1) + ($urandom % 8))) | ROW_W'($urandom % 256);
    endfunction

    // Watchdog: an expired run counts as a failure and still summarises.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        start = 1'b1;
        repeat (3) @(negedge clk);
        check(addr_valid, 1'b0, "R1 reset valid");
        check(done, 1'b0, "R1 reset done");
        start = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(addr_valid, 1'b0, "R1 after reset valid");
        check(done, 1'b0, "R1 after reset done");

        // Directed corners.
        run_cmd(1'b0, 16'h1234, 2'd1, 1'b0, 32'h0, 32'h0, 100, 0);             // R6 empty
        run_cmd(1'b1, 16'hFFFF, 2'd0, 1'b0, 32'h0, 32'h0, 100, 0);             // R4 512
        run_cmd(1'b1, 16'hFFFF, 2'd1, 1'b0, 32'h0, 32'h0, 100, 0);             // R4 2048
        run_cmd(1'b1, 16'hFFFF, 2'd2, 1'b0, 32'h0, 32'h0, 100, 0);             // R4 4096
        run_cmd(1'b1, 16'hABCD, 2'd3, 1'b0, 32'h0, 32'h0, 100, 0);             // R4 reserved
        run_cmd(1'b0, 16'h0, 2'd2, 1'b1, 32'hA1B2C3D4, 32'h0, 100, 0);         // R5 mask zero
        run_cmd(1'b0, 16'h0, 2'd2, 1'b1, 32'hA1B2C3D4, 32'hFFFFFFFF, 100, 0);  // R5 full mask
        run_cmd(1'b1, 16'h1F5A, 2'd2, 1'b1, 32'h00123456, 32'h0001FFFF, 30, 0); // R7 stalls
        run_cmd(1'b1, 16'h0E77, 2'd1, 1'b1, 32'h89ABCDEF, 32'h00FFFFFF, 100, 1); // R2 back-to-back
        run_cmd(1'b1, 16'h0E77, 2'd1, 1'b1, 32'h89ABCDEF, 32'h00FFFFFF, 50, 1);  // R2 stalls

        // Random requests.
        for (int t = 0; t < 600; t++) begin
            run_cmd($urandom % 2, COL_W'($urandom), 2'($urandom), $urandom % 2,
                    $urandom, rand_mask(), 20 + ($urandom % 81), ($urandom % 3) == 0);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule